// File: doc/BRIEF.md
# Lockstep Bit-Flip Fault Injection Comparator

This block runs a deterministic fault injection experiment on a small register-based design under test. Two identical copies of that design share one clock and one stream of workload inputs. The inputs come cycle by cycle from an internal vector memory that is loaded beforehand. One copy is the reference copy and is never disturbed. The other copy is the faulty copy: at a programmed workload cycle, one or more chosen state bits in it are inverted.

Every workload cycle, the block compares the output ports of the two copies. It records three results: whether any divergence occurred, how many cycles passed between the injection and the first divergence, and which output port diverged first. A `start` pulse does four things: it clears both copies, clears the cycle counter, clears the results and latches the injection settings. Because of this, a run with the same settings always gives the same outcome.

The design under test holds 3×W state bits: an accumulator, a shift register and a hidden input register. The hidden register is never visible on an output. A flip in it therefore shows up on the outputs only after some delay.

Top module: `fault_inject_cmp`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `busy`, `done`, `damage`, `latency` and `diverge_port` to zero.
- R2: A write with `vec_we` stores `vec_data` at `vec_addr`. Workload cycle k, counted from 0 as the first cycle after the `start` edge, uses entry k. `busy` is high for exactly `run_len` cycles, then `done` rises and `busy` falls. A `run_len` of 0 counts as 1, and a value above the memory depth counts as the depth.
- R3: Each copy holds state bits [W-1:0] = accumulator (output port 0), [2W-1:W] = shift register (output port 1) and [3W-1:2W] = hidden register. At each clock edge, the hidden register loads the current input, the accumulator adds the hidden register, and the shift register shifts left with the accumulator MSB entering at bit 0.
- R4: For an injection at cycle T, the faulty copy's state during cycle T equals the clean value XOR the mask. T = 0 flips the state that the `start` edge clears.
- R5: The reference copy is never perturbed. With an all-zero mask, or with T not below `run_len`, `damage` stays 0.
- R6: When `multi_mode` is 0, a mask with exactly one bit set is applied. Any other mask applies no flip.
- R7: When `multi_mode` is 1, every set bit of the mask is flipped in the same cycle.
- R8: At the first cycle k in which any output port of the two copies differs, `damage` becomes 1 and `latency` becomes k − T (0 when the divergence is in cycle T itself).
- R9: `diverge_port` is the lowest-numbered port among those that differ in that first divergence cycle.
- R10: Results and `done` hold until the next `start`. Changes to `inj_cycle`, `inj_mask`, `multi_mode` or `run_len` during a run have no effect on that run.
- R11: Two runs with the same settings and the same workload give the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both copies |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_we | input | 1 | Workload memory write enable |
| vec_addr | input | $clog2(DEPTH) | Workload memory write address |
| vec_data | input | W | Workload vector to store |
| start | input | 1 | Clear both copies, latch settings, begin a run |
| run_len | input | $clog2(DEPTH)+1 | Number of workload cycles in the run |
| inj_cycle | input | $clog2(DEPTH)+1 | Injection cycle T |
| inj_mask | input | 3*W | State bits to invert in the faulty copy |
| multi_mode | input | 1 | 1: multi-bit upset, 0: single-bit upset |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| damage | output | 1 | Outputs diverged during the run |
| latency | output | $clog2(DEPTH)+1 | Cycles from injection to first divergence |
| diverge_port | output | 1 | Port that diverged first |

## Verification
The bench flips the hidden register to check that the reported latency is 1 and not 0. A design that applied the flip one edge early or late would report the wrong latency or would flip the wrong cycle's state. One case flips bits in both ports together. A design with inverted port priority would report port 1 for it. Other cases cover an illegal single-mode mask, an injection time past the end of the run, a flip at T = 0 and a run of length 1. The bench also rewrites the settings in the middle of a run. A design that failed to latch them would change its verdict.

// File: rtl/fic_pkg.sv
// Package: constants and helpers shared by the lockstep fault comparator.
// Assumes the design under test has exactly three W-bit state fields.
package fic_pkg;
    localparam int NUM_FIELDS = 3;
    localparam int NUM_PORTS  = 2;

    // Decide whether a latched mask may be applied in the given mode.
    function automatic logic flip_allowed(input logic multi, input int ones);
        return multi || (ones == 1);
    endfunction
endpackage

// File: rtl/fic_dut_core.sv
// Module: small register design that is instantiated twice (reference and faulty).
// State layout: [W-1:0] accumulator, [2W-1:W] shift register, [3W-1:2W] hidden input register.
// Assumes flip is zero whenever neither clear nor en is high.
module fic_dut_core #(
    parameter int W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    clear,
    input  logic                                    en,
    input  logic [W-1:0]                            in_vec,
    input  logic [fic_pkg::NUM_FIELDS*W-1:0]        flip,
    output logic [fic_pkg::NUM_PORTS*W-1:0]         ports
);
    localparam int SB = fic_pkg::NUM_FIELDS * W;

    logic [W-1:0]  acc_q, shf_q, hid_q;
    logic [SB-1:0] nxt;

    // Next-state function of the design under test.
    always_comb nxt = {in_vec, shf_q[W-2:0], acc_q[W-1], acc_q + hid_q};

    // State update: clear loads the flip pattern, a normal step XORs it in.
    always_ff @(posedge clk) begin
        if (!rst_n)     {hid_q, shf_q, acc_q} <= '0;
        else if (clear) {hid_q, shf_q, acc_q} <= flip;
        else if (en)    {hid_q, shf_q, acc_q} <= nxt ^ flip;
    end

    assign ports = {shf_q, acc_q};
endmodule

// File: rtl/fic_vec_mem.sv
// Module: workload vector store, one write port and an asynchronous read port.
// Assumes the host loads the contents before a run; the memory has no reset.
module fic_vec_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // Store a vector when written.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fic_port_cmp.sv
// Module: per-port comparison of the two copies with a lowest-index priority pick.
// Assumes ports are packed W bits each, port 0 in the least significant slice.
module fic_port_cmp #(
    parameter int W     = 8,
    parameter int NPORT = 2,
    parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT*W-1:0] gold,
    input  logic [NPORT*W-1:0] faulty,
    output logic               any,
    output logic [PW-1:0]      first
);
    logic [NPORT-1:0] diff;

    for (genvar p = 0; p < NPORT; p++) begin : g_cmp
        assign diff[p] = gold[p*W +: W] != faulty[p*W +: W];
    end

    // Flag any divergence and pick the lowest diverging port.
    always_comb begin
        any   = |diff;
        first = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (diff[p]) first = PW'(p);
        end
    end
endmodule

// File: rtl/fault_inject_cmp.sv
// Module: top of the lockstep fault injection comparator.
// Sequences the workload, flips the faulty copy at the latched cycle and records
// damage, latency and first diverging port. Assumes vector memory is loaded before start.
module fault_inject_cmp #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               vec_we,
    input  logic [$clog2(DEPTH)-1:0]           vec_addr,
    input  logic [W-1:0]                       vec_data,
    input  logic                               start,
    input  logic [$clog2(DEPTH):0]             run_len,
    input  logic [$clog2(DEPTH):0]             inj_cycle,
    input  logic [fic_pkg::NUM_FIELDS*W-1:0]   inj_mask,
    input  logic                               multi_mode,
    output logic                               busy,
    output logic                               done,
    output logic                               damage,
    output logic [$clog2(DEPTH):0]             latency,
    output logic                               diverge_port
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;
    localparam int SB    = fic_pkg::NUM_FIELDS * W;
    localparam int NPORT = fic_pkg::NUM_PORTS;
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int OW    = NPORT * W;

    logic [CW-1:0] cyc_q, len_q, tinj_q, len_eff;
    logic [SB-1:0] mask_q, flip;
    logic          mask_ok;
    logic [W-1:0]  wl_vec;
    logic [OW-1:0] gold_out, fault_out;
    logic          mism_any;
    logic [PW-1:0] mism_first;

    // Validate the mask for the selected upset mode.
    always_comb mask_ok = fic_pkg::flip_allowed(multi_mode, $countones(inj_mask));

    // Clamp the requested run length into 1..DEPTH.
    always_comb begin
        if (run_len == '0)              len_eff = CW'(1);
        else if (run_len > CW'(DEPTH))  len_eff = CW'(DEPTH);
        else                            len_eff = run_len;
    end

    // Flip pattern for the state being loaded at this edge.
    always_comb begin
        flip = '0;
        if (start) begin
            if (inj_cycle == '0 && mask_ok) flip = inj_mask;
        end else if (busy && (cyc_q + CW'(1) == tinj_q)) begin
            flip = mask_q;
        end
    end

    fic_vec_mem #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(vec_we), .waddr(vec_addr), .wdata(vec_data),
        .raddr(cyc_q[AW-1:0]), .rdata(wl_vec)
    );

    fic_dut_core #(.W(W)) u_gold (
        .clk(clk), .rst_n(rst_n), .clear(start), .en(busy),
        .in_vec(wl_vec), .flip({SB{1'b0}}), .ports(gold_out)
    );

    fic_dut_core #(.W(W)) u_faulty (
        .clk(clk), .rst_n(rst_n), .clear(start), .en(busy),
        .in_vec(wl_vec), .flip(flip), .ports(fault_out)
    );

    fic_port_cmp #(.W(W), .NPORT(NPORT), .PW(PW)) u_cmp (
        .gold(gold_out), .faulty(fault_out), .any(mism_any), .first(mism_first)
    );

    // Run sequencer: latch settings on start, step the cycle counter, end the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cyc_q  <= '0;
            len_q  <= CW'(1);
            tinj_q <= '0;
            mask_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            cyc_q  <= '0;
            len_q  <= len_eff;
            tinj_q <= inj_cycle;
            mask_q <= mask_ok ? inj_mask : '0;
        end else if (busy) begin
            cyc_q <= cyc_q + CW'(1);
            if (cyc_q == len_q - CW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Result register: capture the first divergence of the run.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            damage       <= 1'b0;
            latency      <= '0;
            diverge_port <= 1'b0;
        end else if (busy && mism_any && !damage) begin
            damage       <= 1'b1;
            latency      <= cyc_q - tinj_q;
            diverge_port <= mism_first[0];
        end
    end

    // R5
    gold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cyc_q < tinj_q) |-> !mism_any);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cyc_q == len_q - CW'(1)) |=> (done && !busy));

    // R10
    damage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (damage && !start) |=> damage);

    // R10
    latency_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (damage && !start) |=> ($stable(latency) && $stable(diverge_port)));
endmodule

// File: tb/fault_inject_cmp_tb.sv
module fault_inject_cmp_tb;
    localparam int W = 8, DEPTH = 16, AW = 4, CW = 5, SB = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, vec_we, start, multi_mode;
    logic [AW-1:0] vec_addr;
    logic [W-1:0]  vec_data;
    logic [CW-1:0] run_len, inj_cycle;
    logic [SB-1:0] inj_mask;
    logic          busy, done, damage, diverge_port;
    logic [CW-1:0] latency;

    int checks = 0, fails = 0;
    int wl [DEPTH];

    fault_inject_cmp #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .vec_we(vec_we), .vec_addr(vec_addr),
        .vec_data(vec_data), .start(start), .run_len(run_len),
        .inj_cycle(inj_cycle), .inj_mask(inj_mask), .multi_mode(multi_mode),
        .busy(busy), .done(done), .damage(damage), .latency(latency),
        .diverge_port(diverge_port)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of both copies over a whole run.
    task automatic model(input int t, input logic [SB-1:0] mask, input bit multi, input int len,
                         output int dmg, output int lat, output int prt);
        logic [SB-1:0] m;
        int ga, gs, gh, fa, fs, fh, na, ns;
        m  = (multi || $countones(mask) == 1) ? mask : '0;
        ga = 0; gs = 0; gh = 0;
        fa = 0; fs = 0; fh = 0;
        if (t == 0) begin fa = m[7:0]; fs = m[15:8]; fh = m[23:16]; end
        dmg = 0; lat = 0; prt = 0;
        for (int k = 0; k < len; k++) begin
            if (dmg == 0 && (ga != fa || gs != fs)) begin
                dmg = 1; lat = k - t; prt = (ga != fa) ? 0 : 1;
            end
            na = (ga + gh) & 255; ns = ((gs << 1) | (ga >> 7)) & 255;
            ga = na; gs = ns; gh = wl[k];
            na = (fa + fh) & 255; ns = ((fs << 1) | (fa >> 7)) & 255;
            fa = na; fs = ns; fh = wl[k];
            if (k + 1 == t) begin fa ^= m[7:0]; fs ^= m[15:8]; fh ^= m[23:16]; end
        end
    endtask

    task automatic run(input string req, input int t, input logic [SB-1:0] mask,
                       input bit multi, input int len, input bit poke);
        int dmg, lat, prt;
        model(t, mask, multi, len, dmg, lat, prt);
        @(negedge clk);
        start = 1'b1; run_len = CW'(len); inj_cycle = CW'(t);
        inj_mask = mask; multi_mode = multi;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            inj_mask = ~mask; inj_cycle = '0; run_len = CW'(DEPTH); multi_mode = ~multi;
        end
        for (int k = 0; k < len; k++) begin
            check("R2", "busy during run", int'(busy), 1);
            check("R2", "done during run", int'(done), 0);
            @(negedge clk);
        end
        check("R2", "busy after run", int'(busy), 0);
        check("R2", "done after run", int'(done), 1);
        check(req, "damage", int'(damage), dmg);
        check(req, "latency", int'(latency), lat);
        check(req, "port", int'(diverge_port), prt);
        repeat (3) @(negedge clk);
        check("R10", "damage held", int'(damage), dmg);
        check("R10", "latency held", int'(latency), lat);
        check("R10", "done held", int'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vec_we = 1'b0; start = 1'b0; multi_mode = 1'b0;
        vec_addr = '0; vec_data = '0; run_len = CW'(1); inj_cycle = '0; inj_mask = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "damage", int'(damage), 0);
        check("R1", "latency", int'(latency), 0);
        check("R1", "port", int'(diverge_port), 0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            wl[i] = (i * 37 + 5) & 255;
            vec_we = 1'b1; vec_addr = AW'(i); vec_data = W'(wl[i]);
            @(negedge clk);
        end
        vec_we = 1'b0;

        run("R5", 3, 24'h000000, 1'b0, 16, 1'b0);      // zero mask: no flip
        run("R8", 3, 24'h000080, 1'b0, 16, 1'b0);      // acc MSB: latency 0, port 0
        run("R3", 2, 24'h010000, 1'b0, 16, 1'b0);      // hidden bit: latency 1
        run("R9", 5, 24'h000800, 1'b0, 16, 1'b0);      // shift bit: port 1
        run("R7", 4, 24'h000101, 1'b1, 16, 1'b0);      // both ports same cycle: port 0
        run("R6", 4, 24'h000101, 1'b0, 16, 1'b0);      // two bits in single mode: ignored
        run("R5", 12, 24'h000001, 1'b0, 8, 1'b0);      // T beyond run length
        run("R4", 0, 24'h020000, 1'b0, 16, 1'b0);      // T = 0 into hidden register
        run("R4", 9, 24'h008000, 1'b0, 10, 1'b0);      // last cycle, shift MSB
        run("R2", 0, 24'h000004, 1'b0, 1, 1'b0);       // single-cycle run
        run("R10", 2, 24'h010000, 1'b0, 16, 1'b1);     // settings changed mid-run
        run("R11", 2, 24'h010000, 1'b0, 16, 1'b0);     // repeat gives same result

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule